// File: doc/BRIEF.md
# Local Interrupt Source Dispatcher

This block sits between a processor's local interrupt sources (a countdown timer, two external interrupt pins and a few internal event sources) and the interrupt priority core. Each source owns a programmable table entry that holds a vector number, a delivery mode, a level-trigger flag and a mask flag. When a source fires, the dispatcher looks up that source's entry. It then either pulses one of three special-cycle outputs toward the processor (system-management, non-maskable or external-controller interrupt) or sends a vectored request, with its trigger mode, to the priority core.

The block also handles a falling edge on local pin 0. If that pin is set up as a level-triggered fixed source, the falling edge retracts the pending request by issuing a clear for its vector and asks the core to re-evaluate its interrupt output. If the pin is set up for the external-controller mode, the falling edge only asks for re-evaluation. Entries are written one at a time through a narrow write port. Every action appears as a one-cycle registered pulse in the cycle after the event.

Top module: `lvt_dispatch`

## Requirements
- R1: While reset is asserted every action output is low, and reset leaves every entry masked, so a source firing before any entry write produces no action.
- R2: A write with `cfgWrEn` high stores `cfgWrData` into the entry chosen by `cfgWrSel`. The fields are vector in bits 7:0, delivery mode in bits 10:8, level-trigger flag in bit 15 and mask flag in bit 16. A select value at or above `NUM_SRC` changes no entry.
- R3: When a source fires while its entry's mask flag is 1, no action output pulses in the next cycle.
- R4: An unmasked source whose mode is 010 pulses `smiPulse`, mode 100 pulses `nmiPulse`, and mode 111 pulses `extIntPulse`. The pulse lasts exactly the cycle after the fire, and no request is issued.
- R5: An unmasked source in mode 000 raises `reqValid` for one cycle after the fire, with `vecOut` equal to the entry's vector. `reqLevel` is 1 only when the source is pin 0 or pin 1 and the entry's level flag is 1.
- R6: For sources other than the two pins, the level flag is ignored, and a mode-000 request always carries `reqLevel` = 0.
- R7: A `pin0Fall` while pin 0's entry is in mode 000 with the level flag set raises `clrValid` and `reevalPulse` together for one cycle, with `vecOut` equal to that entry's vector. With the level flag clear, it produces no action.
- R8: A `pin0Fall` while pin 0's entry is in mode 111 raises only `reevalPulse`. In modes 010 and 100 it produces no action.
- R9: The handling of `pin0Fall` does not depend on pin 0's mask flag.
- R10: Mode encodings 001, 011, 101 and 110 produce no action when their source fires.
- R11: When a source fires in the same cycle as a write to its own entry, the action follows the entry contents from before the write.
- R12: `vecOut` is zero in any cycle where neither `reqValid` nor `clrValid` is high. In any one cycle at most one of `smiPulse`, `nmiPulse`, `extIntPulse`, `reqValid` and `reevalPulse` is high. No output pulses in a cycle that does not follow an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgWrSel | input | SEL_W | Index of the entry to write |
| cfgWrData | input | ENTRY_W (17) | New entry contents |
| srcFire | input | NUM_SRC | One-cycle fire pulse per source |
| pin0Fall | input | 1 | One-cycle pulse on deassertion of local pin 0 |
| smiPulse | output | 1 | System-management interrupt pulse |
| nmiPulse | output | 1 | Non-maskable interrupt pulse |
| extIntPulse | output | 1 | External-controller interrupt pulse |
| reqValid | output | 1 | Vectored request to the priority core |
| reqLevel | output | 1 | Request is level-triggered |
| clrValid | output | 1 | Clear the pending bit of `vecOut` |
| reevalPulse | output | 1 | Ask the core to re-evaluate its interrupt output |
| vecOut | output | 8 | Vector for a request or clear |

## Verification
The checker assumes that at most one event arrives per cycle: at most one bit of `srcFire` is set, and `pin0Fall` never coincides with a fire. It flags any cycle where this does not hold. Its other properties rely on that assumption, because the one-hot output property and the rule that a level request comes from a pin source both need a single event per cycle. The random stimulus picks exactly one of the following each cycle: no event, a fire of one source, or a pin-0 fall. Entry writes, including writes to the entry that fires in the same cycle and writes with an out-of-range select, are mixed in freely because they fall outside the assumption.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int VEC_W     = 8;
  localparam int MODE_W    = 3;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int LEVEL_BIT = 15;
  localparam int MASK_BIT  = 16;
  localparam int ENTRY_W   = MASK_BIT + 1;

  localparam logic [MODE_W-1:0] MODE_FIXED = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SMI   = 3'b010;
  localparam logic [MODE_W-1:0] MODE_NMI   = 3'b100;
  localparam logic [MODE_W-1:0] MODE_EXT   = 3'b111;

  typedef struct packed {
    logic              mask;
    logic              level;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } lvtEntry_t;

  typedef struct packed {
    logic             smi;
    logic             nmi;
    logic             ext;
    logic             req;
    logic             reqLevel;
    logic             clr;
    logic             reeval;
    logic [VEC_W-1:0] vector;
  } lvtStrobe_t;

  localparam lvtEntry_t ENTRY_RESET = '{mask: 1'b1, level: 1'b0, mode: MODE_FIXED, vector: '0};
endpackage

// File: rtl/lvt_datapath.sv
module lvt_datapath
  import lvt_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [SEL_W-1:0]     cfgWrSel,
  input  logic [ENTRY_W-1:0]   cfgWrData,
  input  logic [SEL_W-1:0]     selIdx,
  output lvtEntry_t            selEntry,
  input  lvtStrobe_t           strobe,
  output logic                 smiPulse,
  output logic                 nmiPulse,
  output logic                 extIntPulse,
  output logic                 reqValid,
  output logic                 reqLevel,
  output logic                 clrValid,
  output logic                 reevalPulse,
  output logic [VEC_W-1:0]     vecOut
);
  lvtEntry_t entryQ [NUM_SRC];
  lvtEntry_t wrEntry;
  logic      unusedRsvd;

  assign wrEntry.mask   = cfgWrData[MASK_BIT];
  assign wrEntry.level  = cfgWrData[LEVEL_BIT];
  assign wrEntry.mode   = cfgWrData[MODE_LSB +: MODE_W];
  assign wrEntry.vector = cfgWrData[VEC_LSB +: VEC_W];
  assign unusedRsvd     = ^cfgWrData[LEVEL_BIT-1:MODE_LSB+MODE_W];

  // One storage slot per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ[g] <= ENTRY_RESET;
      end else if (cfgWrEn && (cfgWrSel == SEL_W'(g))) begin
        entryQ[g] <= wrEntry;
      end
    end
  end

  // Read the slot the control asks for (pre-write contents)
  always_comb begin
    selEntry = ENTRY_RESET;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (selIdx == SEL_W'(i)) selEntry = entryQ[i];
    end
  end

  // Registered action outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      smiPulse    <= 1'b0;
      nmiPulse    <= 1'b0;
      extIntPulse <= 1'b0;
      reqValid    <= 1'b0;
      reqLevel    <= 1'b0;
      clrValid    <= 1'b0;
      reevalPulse <= 1'b0;
      vecOut      <= '0;
    end else begin
      smiPulse    <= strobe.smi;
      nmiPulse    <= strobe.nmi;
      extIntPulse <= strobe.ext;
      reqValid    <= strobe.req;
      reqLevel    <= strobe.reqLevel;
      clrValid    <= strobe.clr;
      reevalPulse <= strobe.reeval;
      vecOut      <= strobe.vector;
    end
  end
endmodule

// File: rtl/lvt_control.sv
module lvt_control
  import lvt_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int PIN0_IDX = 1,
  parameter int PIN1_IDX = 2,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_SRC-1:0] srcFire,
  input  logic               pin0Fall,
  output logic [SEL_W-1:0]   selIdx,
  input  lvtEntry_t          selEntry,
  output lvtStrobe_t         strobe
);
  logic             fireAny;
  logic [SEL_W-1:0] fireIdx;
  logic             fromPin;

  always_comb begin
    fireIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcFire[i]) fireIdx = SEL_W'(i);
    end
  end

  assign fireAny = |srcFire;
  assign fromPin = (fireIdx == SEL_W'(PIN0_IDX)) || (fireIdx == SEL_W'(PIN1_IDX));
  assign selIdx  = pin0Fall ? SEL_W'(PIN0_IDX) : fireIdx;

  always_comb begin
    strobe = '0;
    if (pin0Fall) begin
      // Deassertion path does not consult the mask flag
      if (selEntry.mode == MODE_FIXED && selEntry.level) begin
        strobe.clr    = 1'b1;
        strobe.reeval = 1'b1;
        strobe.vector = selEntry.vector;
      end else if (selEntry.mode == MODE_EXT) begin
        strobe.reeval = 1'b1;
      end
    end else if (fireAny && !selEntry.mask) begin
      unique case (selEntry.mode)
        MODE_FIXED: begin
          strobe.req      = 1'b1;
          strobe.reqLevel = fromPin && selEntry.level;
          strobe.vector   = selEntry.vector;
        end
        MODE_SMI: strobe.smi = 1'b1;
        MODE_NMI: strobe.nmi = 1'b1;
        MODE_EXT: strobe.ext = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
  import lvt_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int PIN0_IDX = 1,
  parameter int PIN1_IDX = 2,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [SEL_W-1:0]   cfgWrSel,
  input  logic [ENTRY_W-1:0] cfgWrData,
  input  logic [NUM_SRC-1:0] srcFire,
  input  logic               pin0Fall,
  output logic               smiPulse,
  output logic               nmiPulse,
  output logic               extIntPulse,
  output logic               reqValid,
  output logic               reqLevel,
  output logic               clrValid,
  output logic               reevalPulse,
  output logic [VEC_W-1:0]   vecOut
);
  logic [SEL_W-1:0] selIdx;
  lvtEntry_t        selEntry;
  lvtStrobe_t       strobe;

  lvt_control #(
    .NUM_SRC(NUM_SRC), .PIN0_IDX(PIN0_IDX), .PIN1_IDX(PIN1_IDX), .SEL_W(SEL_W)
  ) ctrl_i (
    .srcFire(srcFire), .pin0Fall(pin0Fall), .selIdx(selIdx),
    .selEntry(selEntry), .strobe(strobe)
  );

  lvt_datapath #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .selIdx(selIdx), .selEntry(selEntry), .strobe(strobe),
    .smiPulse(smiPulse), .nmiPulse(nmiPulse), .extIntPulse(extIntPulse),
    .reqValid(reqValid), .reqLevel(reqLevel), .clrValid(clrValid),
    .reevalPulse(reevalPulse), .vecOut(vecOut)
  );
endmodule

// File: rtl/lvt_dispatch_chk.sv
module lvt_dispatch_chk #(
  parameter int NUM_SRC  = 6,
  parameter int PIN0_IDX = 1,
  parameter int PIN1_IDX = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcFire,
  input logic               pin0Fall,
  input logic               smiPulse,
  input logic               nmiPulse,
  input logic               extIntPulse,
  input logic               reqValid,
  input logic               reqLevel,
  input logic               clrValid,
  input logic               reevalPulse,
  input logic [7:0]         vecOut
);
  // R12 (input assumption: one event per cycle)
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({srcFire, pin0Fall}));

  // R12
  action_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({smiPulse, nmiPulse, extIntPulse, reqValid, reevalPulse}));

  // R12
  quiet_without_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcFire == '0 && !pin0Fall) |=> !(smiPulse || nmiPulse || extIntPulse ||
                                      reqValid || clrValid || reevalPulse));

  // R12
  vec_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid || clrValid) |-> vecOut == 8'h00);

  // R7
  clr_with_reeval_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrValid |-> reevalPulse);

  // R7
  fall_no_delivery_chk: assert property (@(posedge clk) disable iff (!rstN)
    pin0Fall |=> !(reqValid || smiPulse || nmiPulse || extIntPulse));

  // R8
  fire_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcFire != '0) |=> !(clrValid || reevalPulse));

  // R6
  level_from_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqLevel |-> (reqValid && $past(srcFire[PIN0_IDX] || srcFire[PIN1_IDX])));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> !(smiPulse || nmiPulse || extIntPulse || reqValid || clrValid || reevalPulse));
endmodule

bind lvt_dispatch lvt_dispatch_chk #(
  .NUM_SRC(NUM_SRC), .PIN0_IDX(PIN0_IDX), .PIN1_IDX(PIN1_IDX)
) chk_i (
  .clk(clk), .rstN(rstN), .srcFire(srcFire), .pin0Fall(pin0Fall),
  .smiPulse(smiPulse), .nmiPulse(nmiPulse), .extIntPulse(extIntPulse),
  .reqValid(reqValid), .reqLevel(reqLevel), .clrValid(clrValid),
  .reevalPulse(reevalPulse), .vecOut(vecOut)
);

// File: tb/lvt_dispatch_tb_top.sv
module lvt_dispatch_tb_top;
  localparam int NS = 6;
  localparam int P0 = 1;
  localparam int P1 = 2;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [SW-1:0] cfgWrSel = '0;
  logic [16:0] cfgWrData = '0;
  logic [NS-1:0] srcFire = '0;
  logic pin0Fall = 1'b0;
  logic smiPulse, nmiPulse, extIntPulse, reqValid, reqLevel, clrValid, reevalPulse;
  logic [7:0] vecOut;

  int testCnt = 0;
  int failCnt = 0;
  logic [16:0] mdl [NS];

  always #5 clk = ~clk;

  lvt_dispatch #(.NUM_SRC(NS), .PIN0_IDX(P0), .PIN1_IDX(P1)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .srcFire(srcFire), .pin0Fall(pin0Fall),
    .smiPulse(smiPulse), .nmiPulse(nmiPulse), .extIntPulse(extIntPulse),
    .reqValid(reqValid), .reqLevel(reqLevel), .clrValid(clrValid),
    .reevalPulse(reevalPulse), .vecOut(vecOut)
  );

  // {smi,nmi,ext,req,lvl,clr,reeval,vec[7:0]}
  function automatic logic [14:0] expOut(int idx, bit fall, logic [16:0] e);
    logic [14:0] r = '0;
    if (fall) begin
      if (e[10:8] == 3'b000 && e[15]) r = {5'b00000, 2'b11, e[7:0]};
      else if (e[10:8] == 3'b111) r = 15'h0100;
    end else if (idx >= 0 && !e[16]) begin
      case (e[10:8])
        3'b000: r = {3'b000, 1'b1, ((idx == P0 || idx == P1) && e[15]), 2'b00, e[7:0]};
        3'b010: r = 15'h4000;
        3'b100: r = 15'h2000;
        3'b111: r = 15'h1000;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string classify(int idx, bit fall, logic [16:0] e);
    if (fall) return e[16] ? "R9" : (e[10:8] == 3'b111 ? "R8" : "R7");
    if (idx < 0) return "R12";
    if (e[16]) return "R3";
    case (e[10:8])
      3'b000: return (idx != P0 && idx != P1 && e[15]) ? "R6" : "R5";
      3'b010, 3'b100, 3'b111: return "R4";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [14:0] actual();
    return {smiPulse, nmiPulse, extIntPulse, reqValid, reqLevel, clrValid, reevalPulse, vecOut};
  endfunction

  task automatic check(string tag, logic [14:0] exp);
    testCnt++;
    if (actual() !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  // One event cycle: drive at negedge, compare at the next negedge
  task automatic step(bit wr, logic [SW-1:0] sel, logic [16:0] data, int idx, bit fall, string tag);
    logic [14:0] exp;
    string t;
    cfgWrEn = wr; cfgWrSel = sel; cfgWrData = data;
    srcFire = (idx >= 0) ? NS'(1) << idx : '0;
    pin0Fall = fall;
    exp = expOut(idx, fall, fall ? mdl[P0] : (idx >= 0 ? mdl[idx] : 17'h0));
    t = (tag == "") ? classify(idx, fall, fall ? mdl[P0] : (idx >= 0 ? mdl[idx] : 17'h0)) : tag;
    if (wr && int'(sel) < NS) mdl[sel] = data;
    @(negedge clk);
    cfgWrEn = 1'b0; srcFire = '0; pin0Fall = 1'b0;
    check(t, exp);
  endtask

  function automatic logic [16:0] ent(bit m, bit l, logic [2:0] md, logic [7:0] v);
    return {m, l, 4'b0000, md, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < NS; i++) mdl[i] = 17'h10000;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rstN = 1'b1;
    // R1: all entries masked after reset
    for (int i = 0; i < NS; i++) step(0, '0, '0, i, 0, "R1");
    // R2 / R4 / R5 directed
    step(1, 3'd0, ent(0, 1, 3'b000, 8'h41), -1, 0, "R2");
    step(0, '0, '0, 0, 0, "R6");
    step(1, 3'd1, ent(0, 1, 3'b000, 8'h52), -1, 0, "R2");
    step(0, '0, '0, 1, 0, "R5");
    step(0, '0, '0, -1, 1, "R7");
    step(1, 3'd1, ent(1, 1, 3'b000, 8'h53), -1, 0, "R2");
    step(0, '0, '0, -1, 1, "R9");
    step(0, '0, '0, 1, 0, "R3");
    step(1, 3'd1, ent(0, 0, 3'b111, 8'h00), -1, 0, "R2");
    step(0, '0, '0, -1, 1, "R8");
    step(0, '0, '0, 1, 0, "R4");
    step(1, 3'd2, ent(0, 1, 3'b010, 8'h77), -1, 0, "R2");
    step(0, '0, '0, 2, 0, "R4");
    step(1, 3'd3, ent(0, 0, 3'b101, 8'h66), -1, 0, "R2");
    step(0, '0, '0, 3, 0, "R10");
    step(1, 3'd6, ent(0, 0, 3'b000, 8'h99), -1, 0, "R2");
    // R11: write and fire the same entry in one cycle
    step(1, 3'd2, ent(0, 0, 3'b000, 8'h12), 2, 0, "R11");
    step(0, '0, '0, 2, 0, "R11");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit wr = ($urandom % 2) == 0;
      logic [SW-1:0] sel = SW'($urandom % 8);
      logic [2:0] md;
      int pick = $urandom % 10;
      int idx = -1;
      bit fall = 0;
      case ($urandom % 6)
        0: md = 3'b000; 1: md = 3'b000; 2: md = 3'b010;
        3: md = 3'b100; 4: md = 3'b111; default: md = 3'($urandom);
      endcase
      if (pick < 6) idx = $urandom % NS;
      else if (pick < 8) fall = 1;
      step(wr, sel, ent(($urandom % 10) < 3, $urandom % 2, md, 8'($urandom)), idx, fall, "");
    end
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule